// File: doc/BRIEF.md
# USB Endpoint Register and Buffer Bank

This block is the software-facing side of a four-endpoint USB device controller. A processor reaches it through an AXI4-Lite slave port to set up the device address, the transceiver control bits and the per-endpoint options. It uses the same port to load and launch outgoing packets, to drain incoming packets and to watch status. Each endpoint owns a small outgoing byte buffer and a small incoming byte buffer. Software reaches both through one byte-wide data register: a write appends to the outgoing buffer and a read takes the next incoming byte.

Toward the USB protocol engine the block presents an abstract packet interface. For outgoing packets it gives a per-endpoint busy vector, plus the packet length and the current byte for an endpoint the engine selects; the engine advances through the packet with a pop strobe and ends it with a done strobe. For incoming packets the engine streams bytes to a selected endpoint and closes the packet with an end strobe that carries the CRC-error and SETUP qualifiers. Bus-reset and start-of-frame pulses, the frame number and the live line state also enter here. A single interrupt output combines the enabled events.

Top module: `usb_ep_regbank`

## Requirements
- R1: Globals sit at 0x00 (control), 0x04 (status) and 0x08 (device address). Endpoint n has five words at 0x0C + 0x14*n + 4*k, with k = 0 config, 1 transmit control, 2 receive control, 3 endpoint status, 4 data. Reads of unmapped addresses and of receive control return zero, and writes to unmapped addresses change nothing.
- R2: A write takes effect only in a cycle where AWVALID and WVALID are both high. One write response follows each accepted write, and read data is returned with RVALID in the cycle after the address is accepted.
- R3: Control bits 8:0 read back, and bits 8:1 drive `phyCtrl`. The device address keeps bits 6:0 and drives `devAddr`. The endpoint config keeps bits 3:0, where bit 1 drives `epStall[n]` and bit 0 drives `epIso[n]`.
- R4: A data-register write appends its low byte to that endpoint's outgoing buffer. A transmit-control write with bit 16 set raises `usbTxBusy[n]` and endpoint-status bit 19, and presents bits 10:0 as the length. The bytes then appear on `usbTxData` for the selected endpoint in write order, one step per `usbTxPop`.
- R5: A pop while busy with no unsent byte left sets endpoint-status bit 20. Start and flush clear it.
- R6: `usbTxDone` clears busy, empties the outgoing buffer and latches a transmit-complete event. A transmit-control write with bit 17 set empties the buffer and clears busy, the underrun flag and the event. A start also clears the event.
- R7: Incoming bytes are stored while receive-ready is clear. The end strobe sets status bit 16 (ready), sets bit 17 from the SETUP qualifier, and leaves the byte count in bits 10:0.
- R8: Status bit 18 is set by a CRC-error end strobe, by bytes beyond the buffer depth (the count stops at the depth), and by any byte or end strobe arriving while ready is set. Such a packet is dropped and the stored data and count are kept.
- R9: A data-register read returns the next stored incoming byte in arrival order, and returns zero once the count is used up.
- R10: A receive-control write with bit 0 (accept) or bit 1 (flush) set clears ready, SETUP, error and count, and rewinds the read position.
- R11: Global status shows bit 13 for a latched bus reset, bit 14 for a pending start-of-frame, bits 12:11 for the live line state and bits 10:0 for the frame number taken at the last start-of-frame. Any write to the status word clears bits 13 and 14.
- R12: `irq` is high whenever (control bit 0 and SOF pending) holds, or any endpoint has (config bit 3 and ready) or (config bit 2 and transmit-complete event).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| axiAwValid | input | 1 | Write address valid |
| axiAwReady | output | 1 | Write address ready |
| axiAwAddr | input | ADDR_W | Write address |
| axiWValid | input | 1 | Write data valid |
| axiWReady | output | 1 | Write data ready |
| axiWData | input | 32 | Write data |
| axiBValid | output | 1 | Write response valid |
| axiBReady | input | 1 | Write response ready |
| axiBResp | output | 2 | Write response code, always OKAY |
| axiArValid | input | 1 | Read address valid |
| axiArReady | output | 1 | Read address ready |
| axiArAddr | input | ADDR_W | Read address |
| axiRValid | output | 1 | Read data valid |
| axiRReady | input | 1 | Read data ready |
| axiRData | output | 32 | Read data |
| axiRResp | output | 2 | Read response code, always OKAY |
| usbTxEp | input | log2(NUM_EP) | Endpoint the engine is sending from |
| usbTxPop | input | 1 | Advance to the next outgoing byte |
| usbTxDone | input | 1 | Outgoing packet finished |
| usbTxData | output | 8 | Current outgoing byte of the selected endpoint |
| usbTxLenSel | output | 11 | Packet length of the selected endpoint |
| usbTxBusy | output | NUM_EP | Per-endpoint packet-pending flags |
| usbRxEp | input | log2(NUM_EP) | Endpoint receiving bytes |
| usbRxValid | input | 1 | Incoming byte strobe |
| usbRxData | input | 8 | Incoming byte |
| usbRxEnd | input | 1 | End of incoming packet |
| usbRxCrcErr | input | 1 | CRC mismatch, qualifies usbRxEnd |
| usbRxSetup | input | 1 | SETUP packet, qualifies usbRxEnd |
| usbBusReset | input | 1 | Bus reset detected pulse |
| usbSof | input | 1 | Start-of-frame pulse |
| usbFrame | input | 11 | Frame number, sampled with usbSof |
| lineState | input | 2 | Live line state (bit 1 D+, bit 0 D-) |
| devAddr | output | 7 | Programmed device address |
| phyCtrl | output | 8 | Transceiver control bits (control bits 8:1) |
| epStall | output | NUM_EP | Per-endpoint stall |
| epIso | output | NUM_EP | Per-endpoint isochronous mode |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest states to reach are the incoming-error cases: a second packet arriving on an endpoint whose first packet has not been drained yet, and a packet that runs one byte past the buffer depth. The bench reaches the first by finishing a SETUP packet, reading only part of it, and then streaming another byte and end strobe to the same endpoint. It then checks that the count and flags show the dropped packet. The second case comes from a loop that pushes depth-plus-one bytes before the end strobe. The outgoing underrun needs pops issued past the written bytes while busy, and the bench drives these from the engine side.

// File: rtl/usb_ep_regbank_pkg.sv
package usb_ep_regbank_pkg;

  localparam int LEN_W   = 11;
  localparam int FRAME_W = 11;

  typedef enum logic [3:0] {
    SEL_NONE  = 4'd0,
    SEL_CTRL  = 4'd1,
    SEL_STAT  = 4'd2,
    SEL_ADDR  = 4'd3,
    SEL_CFG   = 4'd4,
    SEL_TXCTL = 4'd5,
    SEL_RXCTL = 4'd6,
    SEL_STS   = 4'd7,
    SEL_DATA  = 4'd8
  } regSel_e;

  // strobes from the bus control to the register datapath
  typedef struct packed {
    logic    wrEn;
    logic    rdEn;
    regSel_e wrSel;
    regSel_e rdSel;
  } regStrobe_t;

  localparam int TXCTL_START_BIT = 16;
  localparam int TXCTL_FLUSH_BIT = 17;
  localparam int RXCTL_ACCEPT_BIT = 0;
  localparam int RXCTL_FLUSH_BIT  = 1;

endpackage

// File: rtl/usb_ep_regbank_ctrl.sv
module usb_ep_regbank_ctrl
  import usb_ep_regbank_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int ADDR_W = 8,
  parameter int EP_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              axiAwValid,
  output logic              axiAwReady,
  input  logic [ADDR_W-1:0] axiAwAddr,
  input  logic              axiWValid,
  output logic              axiWReady,
  output logic              axiBValid,
  input  logic              axiBReady,
  output logic [1:0]        axiBResp,
  input  logic              axiArValid,
  output logic              axiArReady,
  input  logic [ADDR_W-1:0] axiArAddr,
  output logic              axiRValid,
  input  logic              axiRReady,
  output logic [31:0]       axiRData,
  output logic [1:0]        axiRResp,
  input  logic [31:0]       rdMux,
  output regStrobe_t        strobe,
  output logic [EP_W-1:0]   wrEp,
  output logic [EP_W-1:0]   rdEp
);

  localparam int EP_BASE   = 12;
  localparam int EP_STRIDE = 20;
  localparam int EP_REGS   = 5;

  logic    bValid, rValid;
  logic    wrFire, rdFire;
  regSel_e wrSelD, rdSelD;
  logic [31:0] rDataQ;

  function automatic logic [4+EP_W-1:0] decodeAddr(input logic [ADDR_W-1:0] a);
    regSel_e         s;
    logic [EP_W-1:0] e;
    s = SEL_NONE;
    e = '0;
    if (a == ADDR_W'(0)) s = SEL_CTRL;
    if (a == ADDR_W'(4)) s = SEL_STAT;
    if (a == ADDR_W'(8)) s = SEL_ADDR;
    for (int ep = 0; ep < NUM_EP; ep++) begin
      for (int k = 0; k < EP_REGS; k++) begin
        if (a == ADDR_W'(EP_BASE + EP_STRIDE * ep + 4 * k)) begin
          s = regSel_e'(4'(4 + k));
          e = EP_W'(ep);
        end
      end
    end
    return {s, e};
  endfunction

  always_comb begin
    {wrSelD, wrEp} = decodeAddr(axiAwAddr);
    {rdSelD, rdEp} = decodeAddr(axiArAddr);
  end

  assign axiAwReady = !bValid;
  assign axiWReady  = !bValid;
  assign axiArReady = !rValid;
  assign wrFire     = axiAwValid && axiWValid && !bValid;
  assign rdFire     = axiArValid && !rValid;

  assign strobe.wrEn  = wrFire;
  assign strobe.rdEn  = rdFire;
  assign strobe.wrSel = wrSelD;
  assign strobe.rdSel = rdSelD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bValid <= 1'b0;
      rValid <= 1'b0;
      rDataQ <= '0;
    end else begin
      if (wrFire)         bValid <= 1'b1;
      else if (axiBReady) bValid <= 1'b0;
      if (rdFire) begin
        rValid <= 1'b1;
        rDataQ <= rdMux;
      end else if (axiRReady) begin
        rValid <= 1'b0;
      end
    end
  end

  assign axiBValid = bValid;
  assign axiRValid = rValid;
  assign axiRData  = rDataQ;
  assign axiBResp  = 2'b00;
  assign axiRResp  = 2'b00;

endmodule

// File: rtl/usb_ep_regbank_ep.sv
module usb_ep_regbank_ep
  import usb_ep_regbank_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [3:0]       cfgIn,
  input  logic             txStart,
  input  logic             txFlush,
  input  logic [LEN_W-1:0] txLenIn,
  input  logic             rxClear,
  input  logic             dataWr,
  input  logic [7:0]       dataIn,
  input  logic             dataRd,
  input  logic             txPop,
  input  logic             txDone,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic             rxEnd,
  input  logic             rxCrcErr,
  input  logic             rxSetupIn,
  output logic [3:0]       cfg,
  output logic [LEN_W-1:0] txLen,
  output logic             txBusy,
  output logic             txErr,
  output logic             txEvt,
  output logic [7:0]       txByte,
  output logic             rxReady,
  output logic             rxSetup,
  output logic             rxErr,
  output logic [LEN_W-1:0] rxCount,
  output logic [7:0]       rxByte
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;
  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

  logic [7:0]       txMem [DEPTH];
  logic [7:0]       rxMem [DEPTH];
  logic [PTR_W-1:0] txWr, txRd, rxCnt, rxRd;
  logic             txPush, rxStore, txAvail, rxAvail;

  assign txPush  = dataWr && !txFlush && (txWr < FULL);
  assign rxStore = rxValid && !rxClear && !rxReady && (rxCnt < FULL);
  assign txAvail = txRd < txWr;
  assign rxAvail = rxReady && (rxRd < rxCnt);

  always_ff @(posedge clk) begin
    if (txPush)  txMem[txWr[IDX_W-1:0]] <= dataIn;
    if (rxStore) rxMem[rxCnt[IDX_W-1:0]] <= rxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg    <= '0;
      txLen  <= '0;
      txBusy <= 1'b0;
      txErr  <= 1'b0;
      txEvt  <= 1'b0;
      txWr   <= '0;
      txRd   <= '0;
    end else begin
      if (cfgWr) cfg <= cfgIn;
      if (txFlush) begin
        txWr   <= '0;
        txRd   <= '0;
        txBusy <= 1'b0;
        txErr  <= 1'b0;
        txEvt  <= 1'b0;
      end else begin
        if (txPush) txWr <= txWr + 1'b1;
        if (txDone) begin
          txBusy <= 1'b0;
          txEvt  <= 1'b1;
          txWr   <= '0;
          txRd   <= '0;
        end else if (txPop && txBusy) begin
          if (txAvail) txRd  <= txRd + 1'b1;
          else         txErr <= 1'b1;
        end
      end
      // a start in the same write as a flush launches an empty buffer
      if (txStart) begin
        txBusy <= 1'b1;
        txLen  <= txLenIn;
        txRd   <= '0;
        txErr  <= 1'b0;
        txEvt  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReady <= 1'b0;
      rxSetup <= 1'b0;
      rxErr   <= 1'b0;
      rxCnt   <= '0;
      rxRd    <= '0;
    end else if (rxClear) begin
      rxReady <= 1'b0;
      rxSetup <= 1'b0;
      rxErr   <= 1'b0;
      rxCnt   <= '0;
      rxRd    <= '0;
    end else begin
      if (rxValid) begin
        if (rxStore) rxCnt <= rxCnt + 1'b1;
        else         rxErr <= 1'b1;
      end
      if (rxEnd) begin
        if (rxReady) begin
          rxErr <= 1'b1;
        end else begin
          rxReady <= 1'b1;
          rxSetup <= rxSetupIn;
          if (rxCrcErr) rxErr <= 1'b1;
        end
      end
      if (dataRd && rxAvail) rxRd <= rxRd + 1'b1;
    end
  end

  assign txByte  = txAvail ? txMem[txRd[IDX_W-1:0]] : 8'h00;
  assign rxByte  = rxAvail ? rxMem[rxRd[IDX_W-1:0]] : 8'h00;
  assign rxCount = LEN_W'(rxCnt);

endmodule

// File: rtl/usb_ep_regbank_dp.sv
module usb_ep_regbank_dp
  import usb_ep_regbank_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int DEPTH  = 64,
  parameter int EP_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic [EP_W-1:0]    wrEp,
  input  logic [EP_W-1:0]    rdEp,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdMux,
  input  logic [EP_W-1:0]    usbTxEp,
  input  logic               usbTxPop,
  input  logic               usbTxDone,
  output logic [7:0]         usbTxData,
  output logic [LEN_W-1:0]   usbTxLenSel,
  output logic [NUM_EP-1:0]  usbTxBusy,
  input  logic [EP_W-1:0]    usbRxEp,
  input  logic               usbRxValid,
  input  logic [7:0]         usbRxData,
  input  logic               usbRxEnd,
  input  logic               usbRxCrcErr,
  input  logic               usbRxSetup,
  input  logic               usbBusReset,
  input  logic               usbSof,
  input  logic [FRAME_W-1:0] usbFrame,
  input  logic [1:0]         lineState,
  output logic [6:0]         devAddr,
  output logic [7:0]         phyCtrl,
  output logic [NUM_EP-1:0]  epStall,
  output logic [NUM_EP-1:0]  epIso,
  output logic               irq
);

  logic [8:0]         ctrlReg;
  logic [6:0]         addrReg;
  logic               rstFlag, sofPend;
  logic [FRAME_W-1:0] frameReg;
  logic               unusedWdata;

  logic [3:0]       cfgArr    [NUM_EP];
  logic [LEN_W-1:0] txLenArr  [NUM_EP];
  logic [7:0]       txByteArr [NUM_EP];
  logic [7:0]       rxByteArr [NUM_EP];
  logic [LEN_W-1:0] rxCntArr  [NUM_EP];
  logic [NUM_EP-1:0] txErrV, txEvtV, rxReadyV, rxSetupV, rxErrV, epIrqV;

  assign unusedWdata = ^{wdata[31:18], wdata[15:11]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      addrReg  <= '0;
      rstFlag  <= 1'b0;
      sofPend  <= 1'b0;
      frameReg <= '0;
    end else begin
      if (strobe.wrEn && strobe.wrSel == SEL_CTRL) ctrlReg <= wdata[8:0];
      if (strobe.wrEn && strobe.wrSel == SEL_ADDR) addrReg <= wdata[6:0];
      if (strobe.wrEn && strobe.wrSel == SEL_STAT) begin
        rstFlag <= 1'b0;
        sofPend <= 1'b0;
      end
      // a new event in the clearing cycle wins over the clear
      if (usbBusReset) rstFlag <= 1'b1;
      if (usbSof) begin
        sofPend  <= 1'b1;
        frameReg <= usbFrame;
      end
    end
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic wrHere, rdHere, txCtlWr, rxCtlWr;
    assign wrHere  = strobe.wrEn && (wrEp == EP_W'(e));
    assign rdHere  = strobe.rdEn && (rdEp == EP_W'(e));
    assign txCtlWr = wrHere && strobe.wrSel == SEL_TXCTL;
    assign rxCtlWr = wrHere && strobe.wrSel == SEL_RXCTL;

    usb_ep_regbank_ep #(.DEPTH(DEPTH)) ep_i (
      .clk       (clk),
      .rstN      (rstN),
      .cfgWr     (wrHere && strobe.wrSel == SEL_CFG),
      .cfgIn     (wdata[3:0]),
      .txStart   (txCtlWr && wdata[TXCTL_START_BIT]),
      .txFlush   (txCtlWr && wdata[TXCTL_FLUSH_BIT]),
      .txLenIn   (wdata[LEN_W-1:0]),
      .rxClear   (rxCtlWr && (wdata[RXCTL_ACCEPT_BIT] || wdata[RXCTL_FLUSH_BIT])),
      .dataWr    (wrHere && strobe.wrSel == SEL_DATA),
      .dataIn    (wdata[7:0]),
      .dataRd    (rdHere && strobe.rdSel == SEL_DATA),
      .txPop     (usbTxPop && usbTxEp == EP_W'(e)),
      .txDone    (usbTxDone && usbTxEp == EP_W'(e)),
      .rxValid   (usbRxValid && usbRxEp == EP_W'(e)),
      .rxData    (usbRxData),
      .rxEnd     (usbRxEnd && usbRxEp == EP_W'(e)),
      .rxCrcErr  (usbRxCrcErr),
      .rxSetupIn (usbRxSetup),
      .cfg       (cfgArr[e]),
      .txLen     (txLenArr[e]),
      .txBusy    (usbTxBusy[e]),
      .txErr     (txErrV[e]),
      .txEvt     (txEvtV[e]),
      .txByte    (txByteArr[e]),
      .rxReady   (rxReadyV[e]),
      .rxSetup   (rxSetupV[e]),
      .rxErr     (rxErrV[e]),
      .rxCount   (rxCntArr[e]),
      .rxByte    (rxByteArr[e])
    );

    assign epStall[e] = cfgArr[e][1];
    assign epIso[e]   = cfgArr[e][0];
    assign epIrqV[e]  = (cfgArr[e][3] && rxReadyV[e]) || (cfgArr[e][2] && txEvtV[e]);
  end

  always_comb begin
    rdMux = '0;
    unique case (strobe.rdSel)
      SEL_CTRL:  rdMux = {23'b0, ctrlReg};
      SEL_STAT:  rdMux = {17'b0, sofPend, rstFlag, lineState, frameReg};
      SEL_ADDR:  rdMux = {25'b0, addrReg};
      SEL_CFG:   rdMux = {28'b0, cfgArr[rdEp]};
      SEL_TXCTL: rdMux = {21'b0, txLenArr[rdEp]};
      SEL_STS:   rdMux = {11'b0, txErrV[rdEp], usbTxBusy[rdEp], rxErrV[rdEp],
                          rxSetupV[rdEp], rxReadyV[rdEp], 5'b0, rxCntArr[rdEp]};
      SEL_DATA:  rdMux = {24'b0, rxByteArr[rdEp]};
      default:   rdMux = '0;
    endcase
  end

  assign usbTxData   = txByteArr[usbTxEp];
  assign usbTxLenSel = txLenArr[usbTxEp];
  assign devAddr     = addrReg;
  assign phyCtrl     = ctrlReg[8:1];
  assign irq         = (ctrlReg[0] && sofPend) || (|epIrqV);

endmodule

// File: rtl/usb_ep_regbank.sv
module usb_ep_regbank
  import usb_ep_regbank_pkg::*;
#(
  parameter int NUM_EP    = 4,
  parameter int BUF_DEPTH = 64,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       axiAwValid,
  output logic                       axiAwReady,
  input  logic [ADDR_W-1:0]          axiAwAddr,
  input  logic                       axiWValid,
  output logic                       axiWReady,
  input  logic [31:0]                axiWData,
  output logic                       axiBValid,
  input  logic                       axiBReady,
  output logic [1:0]                 axiBResp,
  input  logic                       axiArValid,
  output logic                       axiArReady,
  input  logic [ADDR_W-1:0]          axiArAddr,
  output logic                       axiRValid,
  input  logic                       axiRReady,
  output logic [31:0]                axiRData,
  output logic [1:0]                 axiRResp,
  input  logic [$clog2(NUM_EP)-1:0]  usbTxEp,
  input  logic                       usbTxPop,
  input  logic                       usbTxDone,
  output logic [7:0]                 usbTxData,
  output logic [10:0]                usbTxLenSel,
  output logic [NUM_EP-1:0]          usbTxBusy,
  input  logic [$clog2(NUM_EP)-1:0]  usbRxEp,
  input  logic                       usbRxValid,
  input  logic [7:0]                 usbRxData,
  input  logic                       usbRxEnd,
  input  logic                       usbRxCrcErr,
  input  logic                       usbRxSetup,
  input  logic                       usbBusReset,
  input  logic                       usbSof,
  input  logic [10:0]                usbFrame,
  input  logic [1:0]                 lineState,
  output logic [6:0]                 devAddr,
  output logic [7:0]                 phyCtrl,
  output logic [NUM_EP-1:0]          epStall,
  output logic [NUM_EP-1:0]          epIso,
  output logic                       irq
);

  localparam int EP_W = $clog2(NUM_EP);

  regStrobe_t      strobe;
  logic [EP_W-1:0] wrEp, rdEp;
  logic [31:0]     rdMux;

  usb_ep_regbank_ctrl #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .EP_W(EP_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .axiAwValid (axiAwValid),
    .axiAwReady (axiAwReady),
    .axiAwAddr  (axiAwAddr),
    .axiWValid  (axiWValid),
    .axiWReady  (axiWReady),
    .axiBValid  (axiBValid),
    .axiBReady  (axiBReady),
    .axiBResp   (axiBResp),
    .axiArValid (axiArValid),
    .axiArReady (axiArReady),
    .axiArAddr  (axiArAddr),
    .axiRValid  (axiRValid),
    .axiRReady  (axiRReady),
    .axiRData   (axiRData),
    .axiRResp   (axiRResp),
    .rdMux      (rdMux),
    .strobe     (strobe),
    .wrEp       (wrEp),
    .rdEp       (rdEp)
  );

  usb_ep_regbank_dp #(.NUM_EP(NUM_EP), .DEPTH(BUF_DEPTH), .EP_W(EP_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrEp        (wrEp),
    .rdEp        (rdEp),
    .wdata       (axiWData),
    .rdMux       (rdMux),
    .usbTxEp     (usbTxEp),
    .usbTxPop    (usbTxPop),
    .usbTxDone   (usbTxDone),
    .usbTxData   (usbTxData),
    .usbTxLenSel (usbTxLenSel),
    .usbTxBusy   (usbTxBusy),
    .usbRxEp     (usbRxEp),
    .usbRxValid  (usbRxValid),
    .usbRxData   (usbRxData),
    .usbRxEnd    (usbRxEnd),
    .usbRxCrcErr (usbRxCrcErr),
    .usbRxSetup  (usbRxSetup),
    .usbBusReset (usbBusReset),
    .usbSof      (usbSof),
    .usbFrame    (usbFrame),
    .lineState   (lineState),
    .devAddr     (devAddr),
    .phyCtrl     (phyCtrl),
    .epStall     (epStall),
    .epIso       (epIso),
    .irq         (irq)
  );

endmodule

// File: rtl/usb_ep_regbank_chk.sv
module usb_ep_regbank_chk #(
  parameter int NUM_EP = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      axiAwValid,
  input logic                      axiWValid,
  input logic                      axiBValid,
  input logic                      axiArValid,
  input logic                      axiRValid,
  input logic [$clog2(NUM_EP)-1:0] usbTxEp,
  input logic                      usbTxDone,
  input logic [NUM_EP-1:0]         usbTxBusy,
  input logic [6:0]                devAddr
);

  logic                      wrPair;
  logic                      doneClean;
  logic [$clog2(NUM_EP)-1:0] doneEp;

  assign wrPair = axiAwValid && axiWValid && !axiBValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneClean <= 1'b0;
      doneEp    <= '0;
    end else begin
      doneClean <= usbTxDone && !wrPair;
      doneEp    <= usbTxEp;
    end
  end

  // R2: a response only after a cycle with both write channels valid
  p_bresp_needs_pair_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(axiBValid) |-> $past(axiAwValid && axiWValid));

  // R2: read data only after a read address
  p_rdata_needs_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(axiRValid) |-> $past(axiArValid));

  // R3: the device address changes only through an accepted write
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrPair |=> $stable(devAddr));

  // R4: busy rises only from a software write
  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|(usbTxBusy & ~$past(usbTxBusy))) |-> $past(wrPair));

  // R6: completion clears busy on its endpoint
  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneClean |-> !usbTxBusy[doneEp]);

endmodule

bind usb_ep_regbank usb_ep_regbank_chk #(.NUM_EP(NUM_EP)) chk_i (.*);

// File: tb/usb_ep_regbank_tb_top.sv
module usb_ep_regbank_tb_top;

  localparam int DEPTH = 64;
  localparam int NVEC  = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        awValid = 0, wValid = 0, bReady = 0, arValid = 0, rReady = 0;
  logic [7:0]  awAddr = 0, arAddr = 0;
  logic [31:0] wData = 0;
  logic        awReady, wReady, bValid, arReady, rValid;
  logic [1:0]  bResp, rResp;
  logic [31:0] rData;
  logic [1:0]  txEp = 0, rxEp = 0;
  logic        txPop = 0, txDone = 0, rxValid = 0, rxEnd = 0, rxCrc = 0, rxSetup = 0;
  logic [7:0]  rxData = 0;
  logic        busReset = 0, sof = 0;
  logic [10:0] frame = 0;
  logic [1:0]  lineSt = 0;
  logic [7:0]  txData;
  logic [10:0] txLenSel;
  logic [3:0]  txBusy, stall, iso;
  logic [6:0]  devAddr;
  logic [7:0]  phyCtrl;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  usb_ep_regbank dut_i (
    .clk(clk), .rstN(rstN),
    .axiAwValid(awValid), .axiAwReady(awReady), .axiAwAddr(awAddr),
    .axiWValid(wValid), .axiWReady(wReady), .axiWData(wData),
    .axiBValid(bValid), .axiBReady(bReady), .axiBResp(bResp),
    .axiArValid(arValid), .axiArReady(arReady), .axiArAddr(arAddr),
    .axiRValid(rValid), .axiRReady(rReady), .axiRData(rData), .axiRResp(rResp),
    .usbTxEp(txEp), .usbTxPop(txPop), .usbTxDone(txDone), .usbTxData(txData),
    .usbTxLenSel(txLenSel), .usbTxBusy(txBusy),
    .usbRxEp(rxEp), .usbRxValid(rxValid), .usbRxData(rxData), .usbRxEnd(rxEnd),
    .usbRxCrcErr(rxCrc), .usbRxSetup(rxSetup),
    .usbBusReset(busReset), .usbSof(sof), .usbFrame(frame), .lineState(lineSt),
    .devAddr(devAddr), .phyCtrl(phyCtrl), .epStall(stall), .epIso(iso), .irq(irq)
  );

  // {write, address, data, expected read}
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 32'h0, 32'h0},
    {1'b1, 8'h00, 32'h1FE, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'h1FE},
    {1'b1, 8'h08, 32'hFF, 32'h0},
    {1'b0, 8'h08, 32'h0, 32'h7F},
    {1'b1, 8'h0C, 32'hFFF3, 32'h0},
    {1'b1, 8'h20, 32'h2, 32'h0},
    {1'b1, 8'h34, 32'h1, 32'h0},
    {1'b0, 8'h0C, 32'h0, 32'h3},
    {1'b0, 8'h20, 32'h0, 32'h2},
    {1'b0, 8'h34, 32'h0, 32'h1},
    {1'b1, 8'h5C, 32'hDEAD, 32'h0},
    {1'b0, 8'h5C, 32'h0, 32'h0},
    {1'b0, 8'h14, 32'h0, 32'h0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic axiWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    awValid = 1; wValid = 1; awAddr = a; wData = d;
    @(posedge clk);
    @(negedge clk);
    awValid = 0; wValid = 0; bReady = 1;
    @(posedge clk);
    @(negedge clk);
    bReady = 0;
  endtask

  task automatic axiRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    arValid = 1; arAddr = a;
    @(posedge clk);
    @(negedge clk);
    arValid = 0; d = rData; rReady = 1;
    @(posedge clk);
    @(negedge clk);
    rReady = 0;
  endtask

  task automatic readCheck(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    axiRead(a, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic rxSend(input logic [7:0] b);
    @(negedge clk); rxValid = 1; rxData = b;
    @(negedge clk); rxValid = 0;
  endtask

  task automatic rxClose(input logic setup, input logic crc);
    @(negedge clk); rxEnd = 1; rxSetup = setup; rxCrc = crc;
    @(negedge clk); rxEnd = 0; rxSetup = 0; rxCrc = 0;
  endtask

  task automatic popOnce();
    @(negedge clk); txPop = 1;
    @(negedge clk); txPop = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // reset state
    check(irq == 0, "R12 reset irq", 32'(irq), 0);
    check(txBusy == 0, "R4 reset busy", 32'(txBusy), 0);
    check(devAddr == 0, "R3 reset addr", 32'(devAddr), 0);
    readCheck(8'h04, 32'h0, "R11 reset status");

    // register table: R1 map, R3 masking
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][72]) axiWrite(VEC[i][71:64], VEC[i][63:32]);
      else            readCheck(VEC[i][71:64], VEC[i][31:0], "R1/R3 table");
    end
    check(phyCtrl == 8'hFF, "R3 phyCtrl", 32'(phyCtrl), 32'hFF);
    check(devAddr == 7'h7F, "R3 devAddr", 32'(devAddr), 32'h7F);
    check(stall == 4'b0011 && iso == 4'b0101, "R3 stall/iso", {stall, iso}, 32'h35);
    axiWrite(8'h00, 32'h0);

    // R2: write address alone, then data alone, are not taken
    @(negedge clk); awValid = 1; awAddr = 8'h08; wData = 32'h12;
    repeat (3) @(negedge clk);
    check(bValid == 0, "R2 addr alone no response", 32'(bValid), 0);
    awValid = 0; wValid = 1;
    repeat (3) @(negedge clk);
    check(bValid == 0, "R2 data alone no response", 32'(bValid), 0);
    wValid = 0;
    readCheck(8'h08, 32'h7F, "R2 unpaired write ignored");

    // transmit on endpoint 1
    axiWrite(8'h20, 32'h4);
    axiWrite(8'h30, 32'h11);
    axiWrite(8'h30, 32'h22);
    axiWrite(8'h30, 32'h33);
    axiWrite(8'h24, 32'h10003);
    check(txBusy == 4'b0010, "R4 busy vector", 32'(txBusy), 2);
    readCheck(8'h2C, 32'h00080000, "R4 status busy");
    readCheck(8'h24, 32'h3, "R4 length readback");
    @(negedge clk); txEp = 1;
    @(negedge clk);
    check(txData == 8'h11 && txLenSel == 11'd3, "R4 first byte", {txLenSel, txData}, 32'h311);
    popOnce();
    check(txData == 8'h22, "R4 second byte", 32'(txData), 32'h22);
    popOnce();
    check(txData == 8'h33, "R4 third byte", 32'(txData), 32'h33);
    popOnce();
    readCheck(8'h2C, 32'h00080000, "R5 no underrun yet");
    popOnce();
    readCheck(8'h2C, 32'h00180000, "R5 underrun flagged");
    check(irq == 0, "R12 no irq before done", 32'(irq), 0);
    @(negedge clk); txDone = 1;
    @(negedge clk); txDone = 0;
    check(txBusy == 0, "R6 done clears busy", 32'(txBusy), 0);
    check(irq == 1, "R12 tx complete irq", 32'(irq), 1);
    readCheck(8'h2C, 32'h00100000, "R6 status after done");
    axiWrite(8'h24, 32'h10000);
    check(irq == 0, "R6 start clears event", 32'(irq), 0);
    readCheck(8'h2C, 32'h00080000, "R5 start clears underrun");
    axiWrite(8'h24, 32'h20000);
    readCheck(8'h2C, 32'h0, "R6 flush clears");
    axiWrite(8'h20, 32'h0);

    // receive on endpoint 2
    axiWrite(8'h34, 32'h9);
    @(negedge clk); rxEp = 2;
    rxSend(8'hA1);
    rxSend(8'hB2);
    check(irq == 0, "R12 no irq mid packet", 32'(irq), 0);
    rxClose(1, 0);
    check(irq == 1, "R12 rx ready irq", 32'(irq), 1);
    readCheck(8'h40, 32'h00030002, "R7 ready setup count");
    readCheck(8'h44, 32'hA1, "R9 first byte");
    rxSend(8'hC3);
    rxClose(0, 0);
    readCheck(8'h40, 32'h00070002, "R8 packet while ready");
    readCheck(8'h44, 32'hB2, "R9 second byte kept");
    readCheck(8'h44, 32'h0, "R9 past count");
    axiWrite(8'h3C, 32'h1);
    readCheck(8'h40, 32'h0, "R10 accept clears");
    check(irq == 0, "R12 irq cleared", 32'(irq), 0);

    // CRC error on endpoint 0
    @(negedge clk); rxEp = 0;
    rxSend(8'h55);
    rxClose(0, 1);
    readCheck(8'h18, 32'h00050001, "R8 crc error");
    axiWrite(8'h14, 32'h2);
    readCheck(8'h18, 32'h0, "R10 flush clears");

    // buffer overflow on endpoint 3
    @(negedge clk); rxEp = 3;
    for (int i = 0; i <= DEPTH; i++) rxSend(8'(i));
    rxClose(0, 0);
    readCheck(8'h54, 32'h00050000 | DEPTH, "R8 overflow");
    readCheck(8'h58, 32'h0, "R9 first overflow byte");
    readCheck(8'h58, 32'h1, "R9 second overflow byte");
    axiWrite(8'h50, 32'h1);

    // bus reset and SOF
    @(negedge clk); lineSt = 2'b01;
    @(negedge clk); busReset = 1;
    @(negedge clk); busReset = 0;
    readCheck(8'h04, 32'h2800, "R11 reset latched");
    axiWrite(8'h04, 32'h0);
    readCheck(8'h04, 32'h0800, "R11 write clears");
    axiWrite(8'h00, 32'h1);
    @(negedge clk); frame = 11'h5A5; sof = 1;
    @(negedge clk); sof = 0;
    check(irq == 1, "R12 sof irq", 32'(irq), 1);
    readCheck(8'h04, 32'h4DA5, "R11 sof frame");
    axiWrite(8'h04, 32'h0);
    check(irq == 0, "R12 sof cleared", 32'(irq), 0);
    readCheck(8'h04, 32'h0DA5, "R11 frame kept");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule